// File: doc/BRIEF.md
# Flash-to-RAM Emulation Overlay Controller

This block lets software develop flash contents in on-chip RAM. A small control register names one of eight 4 KB flash blocks and carries an enable bit. While the enable bit is set, any CPU address that falls inside the chosen flash block is translated into a fixed 4 KB RAM window, and the access is steered to RAM. The same enable bit also drives a global lock that the flash program/erase sequencer must honour, so real flash cannot be altered while it is being emulated.

Address translation is purely combinational, so the overlay adds no cycles to a CPU access. The register is written through a simple write-enable port, read back through a data output, and held unchanged during a low-power standby request. A write to the register needs one clock to settle. For that reason, any access to the overlay-capable flash range in the cycle right after an accepted write is flagged, so that the surrounding system can stall or retry it.

The flash array, the RAM array and the program/erase sequencer are outside this block.

Top module: `flash_ram_overlay`

## Requirements
- R1: After reset the register reads 0x00, the lock output is low, and no flash address is redirected.
- R2: A write stores data bits 3:0. Bits 7:4 always read back as 0, whatever value was written to them.
- R3: The lock output `flash_pe_lock` equals register bit 3 (the enable bit) at all times.
- R4: With bit 3 = 1 and bits 2:0 = n, an address in n×0x1000 to n×0x1000+0xFFF gives `xl_addr` = 0xFFDC00 + addr[11:0] and `ram_sel` = 1.
- R5: An address outside both the selected block and the RAM window passes unchanged with `ram_sel` = 0. While bit 3 = 0, bits 2:0 have no effect on translation.
- R6: An address in 0xFFDC00 to 0xFFEBFF always gives `ram_sel` = 1 and passes unchanged, whatever the register value.
- R7: While `standby_i` is high, register writes are ignored and the register keeps its contents.
- R8: `settle_flag` is 1 only in the cycle directly after an accepted register write, and only when `cpu_rd` or `cpu_wr` is high with an address in 0x000000 to 0x007FFF. In every other case it is 0.
- R9: An accepted write appears on `cfg_rdata` and takes effect on translation after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| standby_i | input | 1 | Standby request; blocks register writes while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cpu_addr | input | 24 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| xl_addr | output | 24 | Translated address |
| ram_sel | output | 1 | High when the access goes to RAM, low when it goes to flash |
| flash_pe_lock | output | 1 | Global program/erase lock for the flash sequencer |
| settle_flag | output | 1 | Marks an overlay-range access in the cycle after a register write |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 4 KB blocks and a 3-bit block select, which give eight blocks. This configuration is small enough for the bench to write all 256 register values and check what reads back. For each of the 16 meaningful register settings, it then sweeps three offsets in every 4 KB block of the lowest 64 KB, together with both edges of the RAM window. The write-settle window and the standby hold are exercised cycle by cycle around individual writes.

// File: rtl/overlay_pkg.sv
package overlay_pkg;
  localparam int unsigned CFG_W = 8;

  typedef enum logic [1:0] {
    ROUTE_FLASH      = 2'd0,
    ROUTE_RAM_DIRECT = 2'd1,
    ROUTE_RAM_EMU    = 2'd2
  } route_e;
endpackage

// File: rtl/overlay_cfg_reg.sv
module overlay_cfg_reg #(
  parameter int unsigned          CFG_W   = 8,
  parameter logic [CFG_W-1:0]     RW_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             standby,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wr_pend
);
  logic             take;
  logic [CFG_W-1:0] cfg_d;

  assign take = wr_en & ~standby;

  always_comb begin
    cfg_d = cfg_q;
    if (take) begin
      cfg_d = wdata & RW_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wr_pend <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      wr_pend <= take;
    end
  end
endmodule

// File: rtl/overlay_decode.sv
module overlay_decode
  import overlay_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BLK_AW     = 12,
  parameter int unsigned       SEL_W      = 3,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 24'hFFDC00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              ram_sel,
  output logic              emu_zone
);
  localparam int unsigned       NUM_BLK  = 1 << SEL_W;
  localparam int unsigned       IDX_W    = ADDR_W - BLK_AW;
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << BLK_AW;
  localparam logic [IDX_W-1:0]  BASE_IDX = FLASH_BASE[ADDR_W-1:BLK_AW];

  logic [IDX_W-1:0]   idx;
  logic [NUM_BLK-1:0] blk_hit;
  logic [ADDR_W-1:0]  ram_off;
  logic               ram_win;
  logic               emu_hit;
  route_e             route;

  assign idx = addr[ADDR_W-1:BLK_AW];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    localparam logic [IDX_W-1:0] G_IDX = BASE_IDX + IDX_W'(g);
    assign blk_hit[g] = (idx == G_IDX);
  end

  assign emu_zone = |blk_hit;
  assign emu_hit  = en & blk_hit[sel];
  assign ram_off  = addr - RAM_BASE;
  assign ram_win  = (addr >= RAM_BASE) && (ram_off < WIN_SIZE);

  always_comb begin
    if (ram_win) begin
      route = ROUTE_RAM_DIRECT;
    end else if (emu_hit) begin
      route = ROUTE_RAM_EMU;
    end else begin
      route = ROUTE_FLASH;
    end
  end

  always_comb begin
    unique case (route)
      ROUTE_RAM_EMU: xl_addr = RAM_BASE + ADDR_W'(addr[BLK_AW-1:0]);
      default:       xl_addr = addr;
    endcase
  end

  assign ram_sel = (route != ROUTE_FLASH);
endmodule

// File: rtl/flash_ram_overlay.sv
module flash_ram_overlay
  import overlay_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BLK_AW     = 12,
  parameter int unsigned       SEL_W      = 3,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 24'hFFDC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              ram_sel,
  output logic              flash_pe_lock,
  output logic              settle_flag
);
  localparam int unsigned      EN_BIT  = SEL_W;
  localparam logic [CFG_W-1:0] RW_MASK = CFG_W'((1 << (SEL_W + 1)) - 1);

  logic rst_meta_q;
  logic core_rst_n;
  logic wr_pend;
  logic emu_zone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  overlay_cfg_reg #(
    .CFG_W   (CFG_W),
    .RW_MASK (RW_MASK)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (cfg_we),
    .standby (standby_i),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_rdata),
    .wr_pend (wr_pend)
  );

  overlay_decode #(
    .ADDR_W     (ADDR_W),
    .BLK_AW     (BLK_AW),
    .SEL_W      (SEL_W),
    .FLASH_BASE (FLASH_BASE),
    .RAM_BASE   (RAM_BASE)
  ) u_dec (
    .addr     (cpu_addr),
    .en       (cfg_rdata[EN_BIT]),
    .sel      (cfg_rdata[SEL_W-1:0]),
    .xl_addr  (xl_addr),
    .ram_sel  (ram_sel),
    .emu_zone (emu_zone)
  );

  assign flash_pe_lock = cfg_rdata[EN_BIT];
  assign settle_flag   = wr_pend & (cpu_rd | cpu_wr) & emu_zone;
endmodule

// File: rtl/overlay_chk.sv
module overlay_chk
  import overlay_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BLK_AW     = 12,
  parameter int unsigned       SEL_W      = 3,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 24'hFFDC00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic              standby_i,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] xl_addr,
  input logic              ram_sel,
  input logic              flash_pe_lock,
  input logic              settle_flag
);
  localparam int unsigned       IDX_W    = ADDR_W - BLK_AW;
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << BLK_AW;
  localparam logic [CFG_W-1:0]  RW_MASK  = CFG_W'((1 << (SEL_W + 1)) - 1);

  logic             in_win;
  logic             live;
  logic [IDX_W-1:0] want_idx;

  assign in_win   = (cpu_addr >= RAM_BASE) && ((cpu_addr - RAM_BASE) < WIN_SIZE);
  assign live     = rst_n && core_rst_n;
  assign want_idx = FLASH_BASE[ADDR_W-1:BLK_AW] + IDX_W'(cfg_rdata[SEL_W-1:0]);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!live)
    (cfg_rdata & ~RW_MASK) == '0);

  // R3
  redirect_lock_chk: assert property (@(posedge clk) disable iff (!live)
    (ram_sel && !in_win) |-> flash_pe_lock);

  // R4
  redirect_target_chk: assert property (@(posedge clk) disable iff (!live)
    (ram_sel && !in_win) |->
      (xl_addr == RAM_BASE + ADDR_W'(cpu_addr[BLK_AW-1:0]))
      && (cpu_addr[ADDR_W-1:BLK_AW] == want_idx));

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!live)
    !ram_sel |-> (xl_addr == cpu_addr));

  // R6
  ram_window_chk: assert property (@(posedge clk) disable iff (!live)
    in_win |-> (ram_sel && xl_addr == cpu_addr));

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!live)
    standby_i |=> $stable(cfg_rdata));

  // R8
  settle_cause_chk: assert property (@(posedge clk) disable iff (!live)
    settle_flag |-> ((cpu_rd || cpu_wr) && $past(cfg_we && !standby_i)));

  // R9
  write_update_chk: assert property (@(posedge clk) disable iff (!live)
    (cfg_we && !standby_i) |=> (cfg_rdata == ($past(cfg_wdata) & RW_MASK)));
endmodule

bind flash_ram_overlay overlay_chk #(
  .ADDR_W     (ADDR_W),
  .BLK_AW     (BLK_AW),
  .SEL_W      (SEL_W),
  .FLASH_BASE (FLASH_BASE),
  .RAM_BASE   (RAM_BASE)
) u_chk (.*);

// File: tb/flash_ram_overlay_test.sv
module flash_ram_overlay_test;
  logic        clk;
  logic        rst_n;
  logic        standby_i;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [23:0] cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [23:0] xl_addr;
  logic        ram_sel;
  logic        flash_pe_lock;
  logic        settle_flag;

  int checks;
  int fails;
  bit done;

  flash_ram_overlay uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .standby_i     (standby_i),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .cpu_addr      (cpu_addr),
    .cpu_rd        (cpu_rd),
    .cpu_wr        (cpu_wr),
    .xl_addr       (xl_addr),
    .ram_sel       (ram_sel),
    .flash_pe_lock (flash_pe_lock),
    .settle_flag   (settle_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic bit in_window(input logic [23:0] a);
    return (a >= 24'hFFDC00) && (a <= 24'hFFEBFF);
  endfunction

  function automatic bit hits(input logic [23:0] a, input logic [3:0] r);
    return r[3] && (a[23:12] == {9'd0, r[2:0]});
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    #1;
  endtask

  task automatic probe(input logic [23:0] a, input logic [3:0] r);
    logic [23:0] ex;
    bit          es;
    string       tag;
    cpu_addr = a;
    #1;
    es  = hits(a, r) || in_window(a);
    ex  = hits(a, r) ? (24'hFFDC00 + {12'd0, a[11:0]}) : a;
    tag = in_window(a) ? "R6" : (hits(a, r) ? "R4" : "R5");
    chk({tag, " xl_addr"}, {8'd0, xl_addr}, {8'd0, ex});
    chk({tag, " ram_sel"}, {31'd0, ram_sel}, {31'd0, es});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks    = 0;
    fails     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    standby_i = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
    cpu_addr  = 24'h000000;
    cpu_rd    = 1'b0;
    cpu_wr    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    chk("R1 cfg_rdata", {24'd0, cfg_rdata}, 32'h0);
    chk("R1 flash_pe_lock", {31'd0, flash_pe_lock}, 32'h0);
    cpu_addr = 24'h000123;
    #1;
    chk("R1 xl_addr", {8'd0, xl_addr}, 32'h000123);
    chk("R1 ram_sel", {31'd0, ram_sel}, 32'h0);

    // R2 R3 R9: every register value, readback on the cycle after the write
    for (int v = 0; v < 256; v++) begin
      write_cfg(8'(v));
      chk("R2/R9 cfg_rdata", {24'd0, cfg_rdata}, v & 32'h0F);
      chk("R3 flash_pe_lock", {31'd0, flash_pe_lock}, (v >> 3) & 1);
    end

    // R4 R5 R6: sweep translation for each meaningful register value
    for (int r = 0; r < 16; r++) begin
      write_cfg(8'(r) | 8'hA0);
      @(negedge clk);
      for (int b = 0; b < 16; b++) begin
        probe(24'(b * 4096), 4'(r));
        probe(24'(b * 4096 + 24'h7A5), 4'(r));
        probe(24'(b * 4096 + 24'hFFF), 4'(r));
      end
      probe(24'hFFDBFF, 4'(r));
      probe(24'hFFDC00, 4'(r));
      probe(24'hFFE3A1, 4'(r));
      probe(24'hFFEBFF, 4'(r));
      probe(24'hFFEC00, 4'(r));
      probe(24'hFFFFFF, 4'(r));
    end

    // R8 settle window after a write
    cpu_addr = 24'h000000;
    write_cfg(8'h0B);
    cpu_addr = 24'h003010;
    cpu_rd   = 1'b1;
    #1;
    chk("R8 settle read in range", {31'd0, settle_flag}, 32'h1);
    cpu_addr = 24'h009000;
    #1;
    chk("R8 settle out of range", {31'd0, settle_flag}, 32'h0);
    cpu_addr = 24'h003010;
    cpu_rd   = 1'b0;
    #1;
    chk("R8 settle no strobe", {31'd0, settle_flag}, 32'h0);
    cpu_rd = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 settle two cycles later", {31'd0, settle_flag}, 32'h0);
    cpu_rd   = 1'b0;
    cpu_addr = 24'h000000;
    write_cfg(8'h02);
    cpu_addr = 24'h007FFF;
    cpu_wr   = 1'b1;
    #1;
    chk("R8 settle write strobe", {31'd0, settle_flag}, 32'h1);
    cpu_wr   = 1'b0;
    cpu_addr = 24'h000000;

    // R7 standby blocks writes and keeps contents
    write_cfg(8'h0B);
    standby_i = 1'b1;
    write_cfg(8'h05);
    chk("R7 cfg_rdata held", {24'd0, cfg_rdata}, 32'h0B);
    chk("R7 lock held", {31'd0, flash_pe_lock}, 32'h1);
    cpu_addr = 24'h003004;
    cpu_rd   = 1'b1;
    #1;
    chk("R7/R8 no settle after ignored write", {31'd0, settle_flag}, 32'h0);
    chk("R7 translation kept", {8'd0, xl_addr}, 32'hFFDC04);
    cpu_rd    = 1'b0;
    standby_i = 1'b0;
    write_cfg(8'h05);
    chk("R7 write after standby", {24'd0, cfg_rdata}, 32'h05);
    finish_run();
  end
endmodule